// File: doc/BRIEF.md
# Interpolated Table Activation Unit

This block evaluates a bounded, odd, S-shaped activation curve on a signed 8-bit fixed-point input for a hardware neural network datapath. It keeps only a coarse set of samples of the curve in a small read-only table. It reconstructs the points between two neighbouring samples with one multiply and one shift. The table is computed at elaboration time from an integer formula, so no file or external tool is needed. The table is split into an even bank and an odd bank, so each bank is read once per cycle and maps onto a single-port block RAM.

A result is produced for every input that is presented with `in_valid`. Inputs can arrive back to back. Each result leaves the block two clock cycles later, with a matching `out_valid`. The output is a signed value with 7 fraction bits. Its magnitude always stays below one.

Top module: `act_lut_interp`

## Requirements
- R1: Sample point p (a signed integer from -16 to 15) holds S(p) = (112*p) / (4+|p|). The division truncates toward zero, and the sample is stored as an 8-bit two's complement value. An input whose 3 low bits are zero produces exactly S(p).
- R2: The input `in_x` is a signed 8-bit value. Sample point p is floor(in_x/8), which is bits [7:3] read as a signed number. The fraction f is bits [2:0] read as unsigned. The table index is k = p + 16, so k is bits [7:3] with bit 7 inverted.
- R3: For k below 31, the output is S(p) + floor((S(p+1) - S(p)) * f / 8), where the floor is an arithmetic right shift by 3.
- R4: At the top index (k = 31, inputs 120 to 127), the output equals S(15) for every fraction, and no entry past the end of the table is read.
- R5: `out_valid` is `in_valid` delayed by exactly two clock cycles. A new input is accepted on every cycle.
- R6: When `out_valid` is low, `out_y` keeps the last valid result.
- R7: While `rst` is high and in the cycle after it is released, `out_valid` and `out_y` are 0.
- R8: `out_y` never takes the value -128, so the output magnitude stays below one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_x | input | 8 | Signed input, 3 fraction bits below the table index |
| out_valid | output | 1 | Result present, two cycles after the input |
| out_y | output | 8 | Signed result, 7 fraction bits |

## Verification
The assertions assume that `in_valid` is low while reset is held. Under that assumption, the two-stage valid pipeline and the checker's own two-deep copy of `in_x` refer to the same post-reset inputs. The stimulus meets this by holding `in_valid` and `in_x` at zero for the whole reset. It drives inputs only on falling clock edges after release. Every one of the 256 input codes is swept twice: once back to back, and once with gaps in `in_valid`, so that the hold behaviour is also exercised.

// File: rtl/act_lut_pkg.sv
package act_lut_pkg;

  // Curve sample at integer point p: odd, bounded by gain, knee sets the bend.
  function automatic int sample_at(input int p, input int gain, input int knee);
    int mag;
    mag = (p < 0) ? -p : p;
    return (gain * p) / (knee + mag);
  endfunction

endpackage

// File: rtl/act_lut_bank.sv
module act_lut_bank #(
  parameter int SAMPLE_W = 8,
  parameter int ENTRIES  = 16,
  parameter int PARITY   = 0,
  parameter int HALF     = 16,
  parameter int GAIN     = 112,
  parameter int KNEE     = 4,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       en,
  input  logic [AW-1:0]              addr,
  output logic signed [SAMPLE_W-1:0] rd
);

  logic signed [SAMPLE_W-1:0] mem [ENTRIES];

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      mem[i] = SAMPLE_W'(act_lut_pkg::sample_at(2 * i + PARITY - HALF, GAIN, KNEE));
    end
  end

  always_ff @(posedge clk) begin
    if (en) rd <= mem[addr];
  end

endmodule

// File: rtl/act_lut_addr.sv
module act_lut_addr #(
  parameter int IN_W   = 8,
  parameter int FRAC_W = 3,
  localparam int IDX_W = IN_W - FRAC_W,
  localparam int BA_W  = IDX_W - 1
) (
  input  logic [IN_W-1:0]   x,
  output logic [FRAC_W-1:0] frac,
  output logic [BA_W-1:0]   even_addr,
  output logic [BA_W-1:0]   odd_addr,
  output logic              idx_odd,
  output logic              idx_top
);

  logic [IDX_W-1:0] k;
  logic [IDX_W:0]   k_inc;

  always_comb begin
    k         = {~x[IN_W-1], x[IN_W-2:FRAC_W]};
    k_inc     = {1'b0, k} + (IDX_W+1)'(1);
    frac      = x[FRAC_W-1:0];
    idx_odd   = k[0];
    idx_top   = &k;
    odd_addr  = k[IDX_W-1:1];
    even_addr = k_inc[IDX_W-1:1];
  end

endmodule

// File: rtl/act_lut_mix.sv
module act_lut_mix #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 3,
  localparam int PW      = SAMPLE_W + FRAC_W + 2
) (
  input  logic signed [SAMPLE_W-1:0] lo,
  input  logic signed [SAMPLE_W-1:0] hi,
  input  logic [FRAC_W-1:0]          frac,
  output logic signed [SAMPLE_W-1:0] y
);

  logic signed [SAMPLE_W:0] diff;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     step;
  logic signed [PW-1:0]     sum;

  always_comb begin
    diff = $signed({hi[SAMPLE_W-1], hi}) - $signed({lo[SAMPLE_W-1], lo});
    prod = PW'(diff) * PW'($signed({1'b0, frac}));
    step = prod >>> FRAC_W;
    sum  = PW'(lo) + step;
    y    = sum[SAMPLE_W-1:0];
  end

endmodule

// File: rtl/act_lut_interp.sv
module act_lut_interp #(
  parameter int IN_W     = 8,
  parameter int FRAC_W   = 3,
  parameter int SAMPLE_W = 8,
  parameter int GAIN     = 112,
  parameter int KNEE     = 4,
  localparam int IDX_W   = IN_W - FRAC_W,
  localparam int DEPTH   = 1 << IDX_W,
  localparam int HALF    = DEPTH / 2,
  localparam int BANK_N  = DEPTH / 2,
  localparam int BA_W    = IDX_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [IN_W-1:0]     in_x,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_y
);

  logic [FRAC_W-1:0] a_frac;
  logic [BA_W-1:0]   a_addr [2];
  logic              a_odd;
  logic              a_top;

  act_lut_addr #(.IN_W(IN_W), .FRAC_W(FRAC_W)) u_addr (
    .x         (in_x),
    .frac      (a_frac),
    .even_addr (a_addr[0]),
    .odd_addr  (a_addr[1]),
    .idx_odd   (a_odd),
    .idx_top   (a_top)
  );

  logic signed [SAMPLE_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    act_lut_bank #(
      .SAMPLE_W (SAMPLE_W),
      .ENTRIES  (BANK_N),
      .PARITY   (b),
      .HALF     (HALF),
      .GAIN     (GAIN),
      .KNEE     (KNEE)
    ) u_bank (
      .clk  (clk),
      .en   (in_valid),
      .addr (a_addr[b]),
      .rd   (bank_rd[b])
    );
  end

  // Stage 1: table read, side information registered alongside
  logic              s1_valid;
  logic [FRAC_W-1:0] s1_frac;
  logic              s1_odd;
  logic              s1_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_frac  <= '0;
      s1_odd   <= 1'b0;
      s1_top   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_frac <= a_frac;
        s1_odd  <= a_odd;
        s1_top  <= a_top;
      end
    end
  end

  logic signed [SAMPLE_W-1:0] lo_s;
  logic signed [SAMPLE_W-1:0] hi_s;
  logic signed [SAMPLE_W-1:0] mix_y;

  always_comb begin
    lo_s = s1_odd ? bank_rd[1] : bank_rd[0];
    hi_s = s1_odd ? bank_rd[0] : bank_rd[1];
    if (s1_top) hi_s = lo_s;
  end

  act_lut_mix #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_mix (
    .lo   (lo_s),
    .hi   (hi_s),
    .frac (s1_frac),
    .y    (mix_y)
  );

  // Stage 2: interpolate and register the result
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_y     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_y <= mix_y;
    end
  end

endmodule

// File: rtl/act_lut_chk.sv
module act_lut_chk #(
  parameter int IN_W     = 8,
  parameter int FRAC_W   = 3,
  parameter int SAMPLE_W = 8,
  parameter int GAIN     = 112,
  parameter int KNEE     = 4,
  localparam int IDX_W   = IN_W - FRAC_W,
  localparam int PMAX    = (1 << (IDX_W - 1)) - 1
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [IN_W-1:0]     in_x,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_y
);

  logic [IN_W-1:0] x_d1, x_d2;

  always_ff @(posedge clk) begin
    x_d1 <= in_x;
    x_d2 <= x_d1;
  end

  int p2;
  logic [SAMPLE_W-1:0] s_at_p2, s_top;

  always_comb begin
    p2      = int'($signed(x_d2)) >>> FRAC_W;
    s_at_p2 = SAMPLE_W'(act_lut_pkg::sample_at(p2, GAIN, KNEE));
    s_top   = SAMPLE_W'(act_lut_pkg::sample_at(PMAX, GAIN, KNEE));
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R5

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R5

  AST_EXACT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && x_d2[FRAC_W-1:0] == '0) |-> out_y == s_at_p2); // R1

  AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && &{~x_d2[IN_W-1], x_d2[IN_W-2:FRAC_W]}) |-> out_y == s_top); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_y)); // R6

  AST_NO_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_y != {1'b1, {(SAMPLE_W-1){1'b0}}}); // R8

endmodule

bind act_lut_interp act_lut_chk #(
  .IN_W(IN_W), .FRAC_W(FRAC_W), .SAMPLE_W(SAMPLE_W), .GAIN(GAIN), .KNEE(KNEE)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/act_lut_interp_bench.sv
module act_lut_interp_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_x = 8'd0;
  logic       out_valid;
  logic [7:0] out_y;

  always #2 clk = ~clk;

  act_lut_interp u_act_lut_interp (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Pending expectations: index 1 was driven one falling edge ago, 2 two ago
  logic       h1_v = 1'b0, h2_v = 1'b0;
  logic [7:0] h1_y = 8'd0, h2_y = 8'd0;
  logic [7:0] h1_x = 8'd0, h2_x = 8'd0;
  logic [7:0] last_y = 8'd0;

  function automatic int samp(input int p);
    int m;
    m = (p < 0) ? -p : p;
    return (112 * p) / (4 + m);
  endfunction

  function automatic logic [7:0] model(input logic [7:0] x);
    int p, f, lo, hi;
    p  = int'($signed(x)) >>> 3;
    f  = int'(x[2:0]);
    lo = samp(p);
    hi = (p == 15) ? lo : samp(p + 1);
    return 8'(lo + (((hi - lo) * f) >>> 3));
  endfunction

  task automatic check(input logic cond, input string req, input int act, input int exp_v);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] x);
    string tag;
    @(negedge clk);
    check(out_valid == h2_v, "R5 valid latency", int'(out_valid), int'(h2_v));
    if (h2_v) begin
      if (h2_x[2:0] == 3'd0) tag = "R1 sample point";
      else if (h2_x[7:3] == 5'b01111) tag = "R4 top clamp";
      else tag = "R2 R3 interpolation";
      check(out_y == h2_y, tag, int'($signed(out_y)), int'($signed(h2_y)));
      check(out_y != 8'h80, "R8 magnitude", int'($signed(out_y)), 0);
      last_y = h2_y;
    end else begin
      check(out_y == last_y, "R6 hold when idle", int'($signed(out_y)), int'($signed(last_y)));
    end
    h2_v = h1_v; h2_y = h1_y; h2_x = h1_x;
    h1_v = v;    h1_y = model(x); h1_x = x;
    in_valid = v;
    in_x     = x;
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R7 reset valid", int'(out_valid), 0);
      check(out_y == 8'd0, "R7 reset data", int'(out_y), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R7 after release valid", int'(out_valid), 0);
    check(out_y == 8'd0, "R7 after release data", int'(out_y), 0);
    // back-to-back sweep of all codes
    for (int i = 0; i < 256; i++) step(1'b1, 8'(i));
    // sweep with gaps and changing data during gaps
    for (int i = 0; i < 256; i++) begin
      step(1'b1, 8'(255 - i));
      if (i % 3 == 1) step(1'b0, 8'(i * 7));
    end
    repeat (4) step(1'b0, 8'h55);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule